// File: doc/BRIEF.md
# Paged Direct-Page Address Translator

This block sits between a small 8-bit processor and its memory system. It takes the 8-bit direct-page address of each access and turns it into a 14-bit physical address. It also reports which target the access reaches: the memory arrays, the index register, or the page register. Two mechanisms widen the reach of the 256-byte direct page. The first is an indirect data location whose target address is held in an 8-bit index register. The second is a 64-byte window at the top of the direct page, which a page register steers onto any 64-byte page of the physical space.

The block owns only the index register and the page register, along with the decode around them. The RAM and nonvolatile arrays live outside it. The read-data path outside the block uses the target select to choose between the addressed memory byte and `reg_rdata`, and it writes memory only when the select reads memory. If the processor touches an unimplemented physical address, the block raises a one-cycle reset request.

Top module: `dpx_top`

## Requirements
- R1: After a synchronous reset the index register reads 0x00 and the page register reads 0x08.
- R2: Direct addresses 0x00–0x0D, 0x10–0x1E and 0x20–0x4F map to the same physical address, with target select 0 (memory).
- R3: An access to direct address 0x0E forms the physical address {6'b0, X}, where X is the index register. That physical address is then decoded like any other physical address.
- R4: An indirect access with X = 0x0E reaches physical RAM 0x000E (target 0). With X = 0x0F it reaches the index register (target 1): a read returns X and a write replaces X.
- R5: Direct address 0x0F reads and writes the index register (target 1), and 0x1F reads and writes the page register (target 2). A write takes effect on the next access, and `reg_rdata` carries the selected register.
- R6: Direct addresses 0xC0–0xFF form the physical address {PAGE[7:0], addr[5:0]}. Page 0x08 lands on 0x0200–0x023F, and pages 0xE0–0xFF land on nonvolatile memory 0x3800–0x3FFF (target 0).
- R7: With the page register at 0x00, window offsets 0xC0–0xCE reach raw RAM 0x0000–0x000E, 0xCF reaches the index register, and 0xDF reaches the page register.
- R8: Physical addresses 0x0050–0x01FF and 0x0240–0x37FF are unimplemented and give target 3. A write to them changes neither register.
- R9: `illegal_rst` is high for exactly one cycle, on the clock after the first cycle of an unbroken run of strobed accesses to unimplemented addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 8 | Direct-page address from the processor |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| phys_addr | output | 14 | Translated physical address |
| tgt_sel | output | 2 | Read mux select: 0 memory, 1 index, 2 page, 3 unimplemented |
| reg_rdata | output | 8 | Value of the selected internal register |
| illegal_rst | output | 1 | One-cycle reset request on an unimplemented access |

## Verification
The bench builds the block with its default parameters: an 8-bit processor address, a 14-bit physical space, a 64-byte window and a reset page of 0x08. With these values every window page from 0x00 to 0xFF can be reached by writing 0x1F. Page 0x00 brings the self-referencing alias of the index and page registers within reach, page 0x04 and page 0x09 reach the unimplemented gaps, and pages 0xE0 and 0xFF reach the two ends of nonvolatile memory. The index register can be set to 0x0E, 0x0F and values above 0x4F, which exercises the raw-RAM case, the self-referencing case and an indirect fault.

// File: rtl/dpx_pkg.sv
package dpx_pkg;

    localparam int ADDR_W    = 8;
    localparam int PHYS_W    = 14;
    localparam int WIN_OFS_W = 6;
    localparam int PAGE_W    = PHYS_W - WIN_OFS_W;

    localparam logic [ADDR_W-1:0] IND_ADDR  = 8'h0E;
    localparam logic [ADDR_W-1:0] XREG_ADDR = 8'h0F;
    localparam logic [ADDR_W-1:0] PAGE_ADDR = 8'h1F;
    localparam logic [ADDR_W-1:0] WIN_BASE  = 8'hC0;
    localparam logic [PAGE_W-1:0] PAGE_RST  = 8'h08;

    localparam logic [PHYS_W-1:0] RAM_LO_END = 14'h000E;
    localparam logic [PHYS_W-1:0] REG_LO     = 14'h0010;
    localparam logic [PHYS_W-1:0] REG_HI     = 14'h001E;
    localparam logic [PHYS_W-1:0] RAM_HI_LO  = 14'h0020;
    localparam logic [PHYS_W-1:0] RAM_HI_HI  = 14'h004F;
    localparam logic [PHYS_W-1:0] HREG_LO    = 14'h0200;
    localparam logic [PHYS_W-1:0] HREG_HI    = 14'h023F;
    localparam logic [PHYS_W-1:0] NVM_LO     = 14'h3800;

    typedef enum logic [1:0] {
        TGT_MEM  = 2'd0,
        TGT_XREG = 2'd1,
        TGT_PAGE = 2'd2,
        TGT_NONE = 2'd3
    } tgt_e;

    typedef struct packed {
        logic [PHYS_W-1:0] addr;
        tgt_e              tgt;
    } xlat_t;

    function automatic tgt_e classify(input logic [PHYS_W-1:0] pa);
        tgt_e t;
        t = TGT_NONE;
        if (pa <= RAM_LO_END)
            t = TGT_MEM;
        else if (pa == {{(PHYS_W-ADDR_W){1'b0}}, XREG_ADDR})
            t = TGT_XREG;
        else if (pa >= REG_LO && pa <= REG_HI)
            t = TGT_MEM;
        else if (pa == {{(PHYS_W-ADDR_W){1'b0}}, PAGE_ADDR})
            t = TGT_PAGE;
        else if (pa >= RAM_HI_LO && pa <= RAM_HI_HI)
            t = TGT_MEM;
        else if (pa >= HREG_LO && pa <= HREG_HI)
            t = TGT_MEM;
        else if (pa >= NVM_LO)
            t = TGT_MEM;
        return t;
    endfunction

endpackage

// File: rtl/dpx_addr_former.sv
module dpx_addr_former
    import dpx_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int PW = PHYS_W,
    parameter int OW = WIN_OFS_W
) (
    input  logic [AW-1:0]    cpu_addr,
    input  logic [AW-1:0]    x_val,
    input  logic [PW-OW-1:0] page_val,
    output logic [PW-1:0]    phys
);
    localparam int ZPAD = PW - AW;

    logic in_window;
    logic is_indirect;

    assign in_window   = (cpu_addr >= WIN_BASE);
    assign is_indirect = (cpu_addr == IND_ADDR);

    always_comb begin
        if (in_window)
            phys = {page_val, cpu_addr[OW-1:0]};
        else if (is_indirect)
            phys = {{ZPAD{1'b0}}, x_val};
        else
            phys = {{ZPAD{1'b0}}, cpu_addr};
    end
endmodule

// File: rtl/dpx_region_decode.sv
module dpx_region_decode
    import dpx_pkg::*;
#(
    parameter int PW = PHYS_W
) (
    input  logic [PW-1:0] phys,
    output xlat_t         xl
);
    always_comb begin
        xl.addr = phys;
        xl.tgt  = classify(phys);
    end
endmodule

// File: rtl/dpx_ctrl_regs.sv
module dpx_ctrl_regs
    import dpx_pkg::*;
#(
    parameter int                 AW        = ADDR_W,
    parameter int                 GW        = PAGE_W,
    parameter logic [PAGE_W-1:0]  PAGE_INIT = PAGE_RST
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  tgt_e          tgt,
    input  logic [AW-1:0] wr_data,
    output logic [AW-1:0] x_q,
    output logic [GW-1:0] page_q,
    output logic [AW-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            x_q    <= '0;
            page_q <= PAGE_INIT;
        end else if (wr_en) begin
            if (tgt == TGT_XREG)
                x_q <= wr_data;
            if (tgt == TGT_PAGE)
                page_q <= wr_data[GW-1:0];
        end
    end

    always_comb begin
        case (tgt)
            TGT_XREG: rdata = x_q;
            TGT_PAGE: rdata = AW'(page_q);
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/dpx_fault_pulse.sv
module dpx_fault_pulse
    import dpx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    input  tgt_e tgt,
    output logic pulse
);
    logic hit;
    logic hit_q;

    assign hit = strobe && (tgt == TGT_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q <= 1'b0;
            pulse <= 1'b0;
        end else begin
            hit_q <= hit;
            pulse <= hit && !hit_q;
        end
    end
endmodule

// File: rtl/dpx_top.sv
module dpx_top
    import dpx_pkg::*;
#(
    parameter logic [PAGE_W-1:0] PAGE_INIT = PAGE_RST
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_data,
    output logic [PHYS_W-1:0] phys_addr,
    output logic [1:0]        tgt_sel,
    output logic [ADDR_W-1:0] reg_rdata,
    output logic              illegal_rst
);
    logic [ADDR_W-1:0] x_q;
    logic [PAGE_W-1:0] page_q;
    logic [PHYS_W-1:0] phys;
    xlat_t             xl;

    dpx_addr_former u_form (
        .cpu_addr (cpu_addr),
        .x_val    (x_q),
        .page_val (page_q),
        .phys     (phys)
    );

    dpx_region_decode u_dec (
        .phys (phys),
        .xl   (xl)
    );

    dpx_ctrl_regs #(.PAGE_INIT(PAGE_INIT)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .tgt     (xl.tgt),
        .wr_data (wr_data),
        .x_q     (x_q),
        .page_q  (page_q),
        .rdata   (reg_rdata)
    );

    dpx_fault_pulse u_fault (
        .clk    (clk),
        .rst    (rst),
        .strobe (rd_en || wr_en),
        .tgt    (xl.tgt),
        .pulse  (illegal_rst)
    );

    assign phys_addr = xl.addr;
    assign tgt_sel   = xl.tgt;
endmodule

// File: rtl/dpx_checker.sv
module dpx_checker
    import dpx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              rd_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_data,
    input logic [PHYS_W-1:0] phys_addr,
    input logic [1:0]        tgt_sel,
    input logic              illegal_rst,
    input logic [ADDR_W-1:0] x_q,
    input logic [PAGE_W-1:0] page_q
);
    logic acc;
    logic bad;
    logic bad_prev;

    assign acc = rd_en || wr_en;
    assign bad = acc && (tgt_sel == 2'd3);

    always_ff @(posedge clk) begin
        if (rst) bad_prev <= 1'b0;
        else     bad_prev <= bad;
    end

    assert_reset_values_R1: assert property (@(posedge clk)
        $past(rst) && !rst |-> (x_q == 8'h00) && (page_q == 8'h08));

    assert_indirect_self_R4: assert property (@(posedge clk) disable iff (rst)
        acc && cpu_addr == 8'h0E && x_q == 8'h0F |-> tgt_sel == 2'd1);

    assert_xreg_write_R5: assert property (@(posedge clk) disable iff (rst)
        wr_en && tgt_sel == 2'd1 |=> x_q == $past(wr_data));

    assert_window_page_R6: assert property (@(posedge clk) disable iff (rst)
        acc && cpu_addr >= 8'hC0 |-> phys_addr[PHYS_W-1:WIN_OFS_W] == page_q);

    assert_ignored_write_R8: assert property (@(posedge clk) disable iff (rst)
        wr_en && tgt_sel == 2'd3 |=> $stable(x_q) && $stable(page_q));

    assert_fault_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        bad && !bad_prev |=> illegal_rst);

    assert_pulse_single_R9: assert property (@(posedge clk) disable iff (rst)
        illegal_rst |=> !illegal_rst);
endmodule

bind dpx_top dpx_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .cpu_addr    (cpu_addr),
    .rd_en       (rd_en),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .phys_addr   (phys_addr),
    .tgt_sel     (tgt_sel),
    .illegal_rst (illegal_rst),
    .x_q         (x_q),
    .page_q      (page_q)
);

// File: tb/tb_dpx_top.sv
module tb_dpx_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  cpu_addr = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [13:0] phys_addr;
    logic [1:0]  tgt_sel;
    logic [7:0]  reg_rdata;
    logic        illegal_rst;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural reference state
    int  m_x = 0;
    int  m_pg = 8;
    bit  m_prev_bad = 0;
    bit  m_exp_ill = 0;
    byte mem [int];

    always #(CLK_PERIOD/2) clk = ~clk;

    dpx_top dut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .phys_addr(phys_addr), .tgt_sel(tgt_sel),
        .reg_rdata(reg_rdata), .illegal_rst(illegal_rst)
    );

    function automatic int ref_phys(int a);
        if (a >= 'hC0) return m_pg * 64 + (a % 64);
        if (a == 'h0E) return m_x;
        return a;
    endfunction

    function automatic int ref_tgt(int p);
        if (p == 'h0F) return 1;
        if (p == 'h1F) return 2;
        if (p <= 'h4F) return 0;
        if (p >= 'h200 && p <= 'h23F) return 0;
        if (p >= 'h3800 && p <= 'h3FFF) return 0;
        return 3;
    endfunction

    function automatic int mem_rd(int p);
        if (mem.exists(p)) return int'(mem[p]) & 'hFF;
        return 0;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step(string req, int a, bit rd, bit wr, int d);
        int ep, et, ev, got;
        @(negedge clk);
        check("R9", "illegal_rst", int'(illegal_rst), int'(m_exp_ill));
        cpu_addr = a[7:0]; rd_en = rd; wr_en = wr; wr_data = d[7:0];
        #1;
        ep = ref_phys(a);
        et = ref_tgt(ep);
        if (rd || wr) begin
            check(req, "phys", int'(phys_addr), ep);
            check(req, "tgt", int'(tgt_sel), et);
        end
        if (rd && et != 3) begin
            ev  = (et == 1) ? m_x : (et == 2) ? m_pg : mem_rd(ep);
            got = (tgt_sel == 2'd0) ? mem_rd(int'(phys_addr)) : int'(reg_rdata);
            check(req, "rdata", got, ev);
        end
        @(posedge clk);
        if (wr) begin
            if (et == 0) mem[ep] = byte'(d);
            else if (et == 1) m_x = d & 'hFF;
            else if (et == 2) m_pg = d & 'hFF;
        end
        m_exp_ill = (rd || wr) && et == 3 && !m_prev_bad;
        m_prev_bad = (rd || wr) && et == 3;
    endtask

    task automatic idle();
        step("R9", 0, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R1 reset values
        step("R1", 'h0F, 1, 0, 0);
        step("R1", 'h1F, 1, 0, 0);
        // R2 direct regions
        step("R2", 'h05, 0, 1, 'hAA);
        step("R2", 'h05, 1, 0, 0);
        step("R2", 'h12, 0, 1, 'h33);
        step("R2", 'h12, 1, 0, 0);
        step("R2", 'h2A, 0, 1, 'h5C);
        step("R2", 'h4F, 0, 1, 'h4E);
        step("R2", 'h4F, 1, 0, 0);
        // R5 index register, R3 indirect
        step("R5", 'h0F, 0, 1, 'h2A);
        step("R5", 'h0F, 1, 0, 0);
        step("R3", 'h0E, 1, 0, 0);
        step("R3", 'h0E, 0, 1, 'h77);
        step("R3", 'h2A, 1, 0, 0);
        // R4 self-referencing cases
        step("R4", 'h0F, 0, 1, 'h0E);
        step("R4", 'h0E, 0, 1, 'h99);
        step("R4", 'h0E, 1, 0, 0);
        step("R4", 'h0F, 0, 1, 'h0F);
        step("R4", 'h0E, 1, 0, 0);
        step("R4", 'h0E, 0, 1, 'h05);
        step("R4", 'h0F, 1, 0, 0);
        step("R4", 'h0E, 1, 0, 0);
        // R7 page 0 aliasing
        step("R5", 'h1F, 0, 1, 'h00);
        step("R7", 'hC5, 1, 0, 0);
        step("R7", 'hCE, 1, 0, 0);
        step("R7", 'hCF, 1, 0, 0);
        step("R7", 'hCF, 0, 1, 'h10);
        step("R7", 'h0F, 1, 0, 0);
        step("R7", 'hDF, 1, 0, 0);
        step("R7", 'hDF, 0, 1, 'hE0);
        step("R5", 'h1F, 1, 0, 0);
        // R6 window onto nonvolatile and high registers
        step("R6", 'hC3, 0, 1, 'h11);
        step("R6", 'hC3, 1, 0, 0);
        step("R6", 'h1F, 0, 1, 'hFF);
        step("R6", 'hFF, 0, 1, 'h3C);
        step("R6", 'hFF, 1, 0, 0);
        step("R6", 'h1F, 0, 1, 'h08);
        step("R6", 'hC0, 0, 1, 'h21);
        step("R6", 'hFF, 1, 0, 0);
        step("R6", 'hC0, 1, 0, 0);
        // R8/R9 unimplemented accesses
        step("R8", 'h50, 1, 0, 0);
        idle();
        step("R8", 'hBF, 1, 0, 0);
        step("R8", 'h60, 0, 1, 'h12);
        step("R8", 'h70, 1, 0, 0);
        idle();
        idle();
        step("R8", 'h0F, 0, 1, 'hC0);
        step("R8", 'h0E, 0, 1, 'h44);
        idle();
        step("R8", 'h0F, 1, 0, 0);
        step("R8", 'h1F, 0, 1, 'h04);
        step("R8", 'hC0, 0, 1, 'hFF);
        idle();
        step("R8", 'h1F, 1, 0, 0);
        step("R8", 'h0F, 1, 0, 0);
        step("R8", 'h1F, 0, 1, 'h09);
        step("R8", 'hC0, 1, 0, 0);
        idle();
        idle();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule